// File: doc/BRIEF.md
# Desaturation Short-Circuit Protection Sequencer

This block sequences short-circuit protection for a single power switch. It takes a drive request that has already been filtered, a synchronous flag from the desaturation comparator, and an active-low fault-clear input. From these it produces the gate-on command, a soft turn-off enable, a discharge control for the blanking capacitor, an active-low fault output and an input-mute flag. Every time interval is a whole number of clock cycles, set by a parameter.

After each turn-on the comparator is ignored for a blanking interval. After that, the comparator must stay tripped for a qualification interval before a fault is declared. A declared fault does not cut the gate hard. The block runs a timed soft turn-off and then latches the fault. The drive request is muted for a fixed interval that begins with the soft turn-off. The latch clears only on a fault-clear pulse of at least a minimum width. After a clear, the gate stays off until the drive request has been seen low. This lets the clear input be tied to the drive input, so that each input pulse clears the fault.

Top module: `desat_guard`

## Requirements
- R1: While `rst_n` is low, `gate_on`=0, `soft_off_en`=0, `blank_dischg`=1, `fault_n`=1 and `in_mute`=0.
- R2: With no fault, no mute and `flt_clr_n` high, `drive_req` sampled high at a clock edge turns `gate_on` on after that edge. `drive_req` sampled low turns it off after that edge.
- R3: For the first BLANK_CYC cycles of every on-period, `desat_trip` is ignored. If the trip is held from turn-on, `gate_on` stays high for exactly BLANK_CYC+1+FILT_CYC cycles.
- R4: A fault needs `desat_trip` high at FILT_CYC+1 consecutive edges once blanking has ended. A trip held for only FILT_CYC edges and then dropped leaves `gate_on` high and never raises `soft_off_en`.
- R5: On a declared fault, `gate_on` falls and `soft_off_en` is high for exactly SOFT_CYC cycles. `fault_n` goes low in the cycle after the last soft turn-off cycle.
- R6: `in_mute` is high for exactly MUTE_CYC cycles, starting in the first soft turn-off cycle. While it is high, `drive_req` cannot turn the gate on.
- R7: While `fault_n` is low, `gate_on` stays low whatever `drive_req` does, including after the mute has ended.
- R8: A clear pulse shorter than RST_MIN_CYC sampled-low cycles leaves the fault latched. After a pulse of at least RST_MIN_CYC low samples, `fault_n` returns high in the cycle after the rising edge is sampled.
- R9: `flt_clr_n` sampled low forces `gate_on` low after that edge and prevents any turn-on.
- R10: After a clear, `gate_on` stays low until `drive_req` has been sampled low. The next request then turns the gate on.
- R11: `blank_dischg` is high whenever `gate_on` is low and low during on-periods, so each on-period restarts blanking from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_req | input | 1 | Filtered gate drive request |
| desat_trip | input | 1 | Synchronous desaturation comparator flag |
| flt_clr_n | input | 1 | Active-low fault clear; low also blocks driving |
| gate_on | output | 1 | Gate-on command |
| soft_off_en | output | 1 | Soft turn-off path enable |
| blank_dischg | output | 1 | Blanking capacitor discharge control |
| fault_n | output | 1 | Active-low latched fault indication |
| in_mute | output | 1 | Drive inputs muted after a fault |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only between active edges, and that every time parameter is at least one. The soft turn-off and mute checks also assume that MUTE_CYC is no shorter than SOFT_CYC. The stimulus drives every input on the falling clock edge. It draws clear-pulse lengths at random on both sides of the minimum width, and it runs with parameters that keep MUTE_CYC above SOFT_CYC. Directed sequences reach the exact trip and clear-width boundaries, and a random phase mixes requests, trips and clear bursts.

// File: rtl/desat_pkg.sv
package desat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BLANK   = 3'd1,
    ST_WATCH   = 3'd2,
    ST_FILTER  = 3'd3,
    ST_SOFTOFF = 3'd4,
    ST_LATCHED = 3'd5
  } dg_state_e;
endpackage

// File: rtl/dg_clr_qual.sv
// Qualifies the fault-clear input: counts sampled-low cycles and flags a
// rising edge that ends a sufficiently long low pulse.
module dg_clr_qual #(
  parameter int RST_MIN_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic clr_valid_o
);
  localparam int CW = $clog2(RST_MIN_CYC + 1);
  localparam logic [CW-1:0] MIN_V = CW'(RST_MIN_CYC);

  logic [CW-1:0] low_q, low_d;
  logic          low_en;

  always_comb begin
    low_en = 1'b0;
    low_d  = low_q;
    if (clr_n) begin
      low_en = 1'b1;
      low_d  = '0;
    end else if (low_q != MIN_V) begin
      low_en = 1'b1;
      low_d  = low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= low_d;
    end
  end

  // A nonzero count means the previous sample was low, so clr_n high now is a rising edge.
  assign clr_valid_o = clr_n && (low_q >= MIN_V);
endmodule

// File: rtl/dg_mute_timer.sv
// Down-counter holding the input mute for a fixed number of cycles.
module dg_mute_timer #(
  parameter int MUTE_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic mute_o
);
  localparam int MW = $clog2(MUTE_CYC + 1);
  localparam logic [MW-1:0] LOAD_V = MW'(MUTE_CYC);

  logic [MW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign mute_o = (cnt_q != '0);
endmodule

// File: rtl/dg_seq_fsm.sv
// Protection sequence: blanking, monitoring, trip qualification, soft off, latch.
module dg_seq_fsm
  import desat_pkg::*;
#(
  parameter int BLANK_CYC = 112,
  parameter int FILT_CYC  = 92,
  parameter int SOFT_CYC  = 137
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      drive_ok,
  input  logic      desat_trip,
  input  logic      clr_valid,
  output dg_state_e state_o,
  output logic      mute_start_o,
  output logic      leave_latch_o
);
  localparam int BF_MAX = (BLANK_CYC > FILT_CYC) ? BLANK_CYC : FILT_CYC;
  localparam int PMAX   = (BF_MAX > SOFT_CYC) ? BF_MAX : SOFT_CYC;
  localparam int PW     = $clog2(PMAX + 1);
  localparam logic [PW-1:0] BLANK_LAST = PW'(BLANK_CYC - 1);
  localparam logic [PW-1:0] FILT_LAST  = PW'(FILT_CYC - 1);
  localparam logic [PW-1:0] SOFT_LAST  = PW'(SOFT_CYC - 1);

  dg_state_e     st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          ph_en;

  always_comb begin
    st_d          = st_q;
    ph_d          = ph_q;
    ph_en         = 1'b0;
    mute_start_o  = 1'b0;
    leave_latch_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (drive_ok) begin
          st_d  = ST_BLANK;
          ph_d  = '0;
          ph_en = 1'b1;
        end
      end
      ST_BLANK: begin
        if (!drive_ok) begin
          st_d = ST_IDLE;
        end else if (ph_q == BLANK_LAST) begin
          st_d  = ST_WATCH;
          ph_d  = '0;
          ph_en = 1'b1;
        end else begin
          ph_d  = ph_q + 1'b1;
          ph_en = 1'b1;
        end
      end
      ST_WATCH: begin
        if (!drive_ok) begin
          st_d = ST_IDLE;
        end else if (desat_trip) begin
          st_d  = ST_FILTER;
          ph_d  = '0;
          ph_en = 1'b1;
        end
      end
      ST_FILTER: begin
        if (!drive_ok) begin
          st_d = ST_IDLE;
        end else if (!desat_trip) begin
          st_d = ST_WATCH;
        end else if (ph_q == FILT_LAST) begin
          st_d         = ST_SOFTOFF;
          ph_d         = '0;
          ph_en        = 1'b1;
          mute_start_o = 1'b1;
        end else begin
          ph_d  = ph_q + 1'b1;
          ph_en = 1'b1;
        end
      end
      ST_SOFTOFF: begin
        if (ph_q == SOFT_LAST) begin
          st_d = ST_LATCHED;
        end else begin
          ph_d  = ph_q + 1'b1;
          ph_en = 1'b1;
        end
      end
      ST_LATCHED: begin
        if (clr_valid) begin
          st_d          = ST_IDLE;
          leave_latch_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      if (ph_en) begin
        ph_q <= ph_d;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import desat_pkg::*;
#(
  parameter int BLANK_CYC   = 112,
  parameter int FILT_CYC    = 92,
  parameter int SOFT_CYC    = 137,
  parameter int MUTE_CYC    = 1250,
  parameter int RST_MIN_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_req,
  input  logic desat_trip,
  input  logic flt_clr_n,
  output logic gate_on,
  output logic soft_off_en,
  output logic blank_dischg,
  output logic fault_n,
  output logic in_mute
);
  dg_state_e st;
  logic      clr_valid, mute_start, leave_latch, mute_q;
  logic      need_low_q, need_low_d, drive_ok;

  dg_clr_qual #(.RST_MIN_CYC(RST_MIN_CYC)) clr_qual_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (flt_clr_n),
    .clr_valid_o(clr_valid)
  );

  dg_mute_timer #(.MUTE_CYC(MUTE_CYC)) mute_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(mute_start),
    .mute_o (mute_q)
  );

  dg_seq_fsm #(
    .BLANK_CYC(BLANK_CYC),
    .FILT_CYC (FILT_CYC),
    .SOFT_CYC (SOFT_CYC)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_ok     (drive_ok),
    .desat_trip   (desat_trip),
    .clr_valid    (clr_valid),
    .state_o      (st),
    .mute_start_o (mute_start),
    .leave_latch_o(leave_latch)
  );

  // Request honoured only with clear released, no mute, and re-arm done.
  assign drive_ok = drive_req & flt_clr_n & ~mute_q & ~need_low_q;

  always_comb begin
    if (leave_latch) begin
      need_low_d = drive_req;
    end else begin
      need_low_d = need_low_q & drive_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_low_q <= 1'b0;
    end else begin
      need_low_q <= need_low_d;
    end
  end

  always_comb begin
    gate_on     = 1'b0;
    soft_off_en = 1'b0;
    fault_n     = 1'b1;
    case (st)
      ST_BLANK, ST_WATCH, ST_FILTER: gate_on = 1'b1;
      ST_SOFTOFF: soft_off_en = 1'b1;
      ST_LATCHED: fault_n     = 1'b0;
      default: ;
    endcase
    blank_dischg = ~gate_on;
  end

  assign in_mute = mute_q;
endmodule

// File: rtl/desat_guard_chk.sv
module desat_guard_chk #(
  parameter int BLANK_CYC = 112,
  parameter int FILT_CYC  = 92
) (
  input logic clk,
  input logic rst_n,
  input logic drive_req,
  input logic flt_clr_n,
  input logic gate_on,
  input logic soft_off_en,
  input logic blank_dischg,
  input logic fault_n,
  input logic in_mute
);
  localparam int OMAX = BLANK_CYC + FILT_CYC + 2;
  localparam int OW   = $clog2(OMAX + 1);
  localparam logic [OW-1:0] OMAX_V = OW'(OMAX);
  localparam logic [OW-1:0] MIN_ON = OW'(BLANK_CYC + FILT_CYC);

  logic [OW-1:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt <= '0;
    end else if (!gate_on) begin
      on_cnt <= '0;
    end else if (on_cnt != OMAX_V) begin
      on_cnt <= on_cnt + 1'b1;
    end
  end

  AST_TURNON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(drive_req)); // R2
  AST_BLANK_FILTER_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_off_en) |-> (on_cnt >= MIN_ON)); // R3
  AST_SOFT_FOLLOWS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_off_en) |-> $past(gate_on)); // R5
  AST_SOFT_EXCLUDES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_off_en && gate_on)); // R5
  AST_FAULT_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(soft_off_en)); // R5
  AST_MUTE_WITH_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mute) |-> soft_off_en); // R6
  AST_NO_TURNON_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> !$past(in_mute)); // R6
  AST_FAULT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !gate_on); // R7
  AST_CLR_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_clr_n |=> !gate_on); // R9
  AST_TURNON_FROM_DISCHG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(blank_dischg)); // R11
endmodule

bind desat_guard desat_guard_chk #(
  .BLANK_CYC(BLANK_CYC),
  .FILT_CYC (FILT_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .drive_req   (drive_req),
  .flt_clr_n   (flt_clr_n),
  .gate_on     (gate_on),
  .soft_off_en (soft_off_en),
  .blank_dischg(blank_dischg),
  .fault_n     (fault_n),
  .in_mute     (in_mute)
);

// File: tb/desat_guard_tb_top.sv
`timescale 1ns/1ps
module desat_guard_tb_top;
  localparam int P_BLANK = 8;
  localparam int P_FILT  = 5;
  localparam int P_SOFT  = 6;
  localparam int P_MUTE  = 40;
  localparam int P_RMIN  = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic drv, trip, clr_n;
  logic gate_on, soft_off_en, blank_dischg, fault_n, in_mute;

  int n_chk  = 0;
  int n_fail = 0;
  int soft_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  desat_guard #(
    .BLANK_CYC  (P_BLANK),
    .FILT_CYC   (P_FILT),
    .SOFT_CYC   (P_SOFT),
    .MUTE_CYC   (P_MUTE),
    .RST_MIN_CYC(P_RMIN)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_req   (drv),
    .desat_trip  (trip),
    .flt_clr_n   (clr_n),
    .gate_on     (gate_on),
    .soft_off_en (soft_off_en),
    .blank_dischg(blank_dischg),
    .fault_n     (fault_n),
    .in_mute     (in_mute)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference built from the requirements (0 idle,1 blank,2 watch,3 qualify,4 soft,5 latched)
  int m_st, m_ph, m_mute, m_low;
  bit m_need;

  task automatic model_step();
    int  ns, nph;
    bit  valid, eff, start, leave;
    valid = clr_n && (m_low >= P_RMIN);
    eff   = drv && clr_n && (m_mute == 0) && !m_need;
    ns = m_st; nph = m_ph; start = 0; leave = 0;
    case (m_st)
      0: if (eff) begin ns = 1; nph = 0; end
      1: if (!eff) ns = 0; else if (m_ph == P_BLANK - 1) begin ns = 2; nph = 0; end else nph = m_ph + 1;
      2: if (!eff) ns = 0; else if (trip) begin ns = 3; nph = 0; end
      3: if (!eff) ns = 0; else if (!trip) ns = 2;
         else if (m_ph == P_FILT - 1) begin ns = 4; nph = 0; start = 1; end else nph = m_ph + 1;
      4: if (m_ph == P_SOFT - 1) ns = 5; else nph = m_ph + 1;
      default: if (valid) begin ns = 0; leave = 1; end
    endcase
    m_mute = start ? P_MUTE : ((m_mute > 0) ? m_mute - 1 : 0);
    m_low  = clr_n ? 0 : ((m_low < P_RMIN) ? m_low + 1 : m_low);
    m_need = leave ? drv : (m_need && drv);
    m_st = ns; m_ph = nph;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_mute = 0; m_low = 0; m_need = 0;
    end else begin
      model_step();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 gate_on vs reference", int'(gate_on), int'(m_st >= 1 && m_st <= 3));
      chk("R5 soft_off_en vs reference", int'(soft_off_en), int'(m_st == 4));
      chk("R11 blank_dischg vs reference", int'(blank_dischg), int'(!(m_st >= 1 && m_st <= 3)));
      chk("R7 fault_n vs reference", int'(fault_n), int'(m_st != 5));
      chk("R6 in_mute vs reference", int'(in_mute), int'(m_mute != 0));
      if (soft_off_en) soft_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int on_len, soft_len, mute_len, sc, burst;
    void'($urandom(32'h1F2E3D));
    rst_n = 1'b0; drv = 1'b1; trip = 1'b1; clr_n = 1'b1;
    cyc(3);
    chk("R1 gate_on in reset", int'(gate_on), 0);
    chk("R1 soft_off_en in reset", int'(soft_off_en), 0);
    chk("R1 blank_dischg in reset", int'(blank_dischg), 1);
    chk("R1 fault_n in reset", int'(fault_n), 1);
    chk("R1 in_mute in reset", int'(in_mute), 0);
    drv = 1'b0; trip = 1'b0;
    rst_n = 1'b1;
    cyc(2);

    // R3/R5/R6: trip held from turn-on
    drv = 1'b1; trip = 1'b1;
    cyc(1);
    chk("R2 turn-on after one edge", int'(gate_on), 1);
    on_len = 0;
    while (gate_on && on_len < 1000) begin on_len++; cyc(1); end
    chk("R3 on-time with trip held", on_len, P_BLANK + 1 + P_FILT);
    soft_len = 0; mute_len = 0;
    while (soft_off_en && soft_len < 1000) begin
      soft_len++;
      if (in_mute) mute_len++;
      cyc(1);
    end
    chk("R5 soft turn-off length", soft_len, P_SOFT);
    chk("R5 fault after soft off", int'(fault_n), 0);
    while (in_mute && mute_len < 1000) begin mute_len++; cyc(1); end
    chk("R6 mute length", mute_len, P_MUTE);
    trip = 1'b0;
    cyc(10);
    chk("R7 gate held off after mute", int'(gate_on), 0);
    chk("R7 fault still latched", int'(fault_n), 0);

    // R8: short clear then valid clear
    drv = 1'b0;
    clr_n = 1'b0; cyc(P_RMIN - 1); clr_n = 1'b1;
    cyc(3);
    chk("R8 short clear ignored", int'(fault_n), 0);
    clr_n = 1'b0; cyc(P_RMIN); clr_n = 1'b1;
    cyc(1);
    chk("R8 clear at minimum width", int'(fault_n), 1);

    // R4: trip held F edges into qualification, then dropped
    drv = 1'b1; trip = 1'b0;
    cyc(P_BLANK + 4);
    sc = soft_seen;
    trip = 1'b1; cyc(P_FILT); trip = 1'b0;
    cyc(4);
    chk("R4 short trip no soft off", soft_seen - sc, 0);
    chk("R4 gate stays on", int'(gate_on), 1);

    // R9: clear low blocks driving
    clr_n = 1'b0;
    cyc(1);
    chk("R9 gate off on clear low", int'(gate_on), 0);
    cyc(3);
    chk("R9 gate held off", int'(gate_on), 0);
    clr_n = 1'b1;
    cyc(1);
    chk("R2 turn-on after clear release", int'(gate_on), 1);
    chk("R11 discharge off when on", int'(blank_dischg), 0);
    drv = 1'b0;
    cyc(1);
    chk("R2 turn-off", int'(gate_on), 0);
    chk("R11 discharge on when off", int'(blank_dischg), 1);

    // R10: clear tied to drive input
    drv = 1'b1; trip = 1'b1;
    on_len = 0;
    while (fault_n && on_len < 1000) begin on_len++; cyc(1); end
    trip = 1'b0;
    on_len = 0;
    while (in_mute && on_len < 1000) begin on_len++; cyc(1); end
    drv = 1'b0; clr_n = 1'b0; cyc(P_RMIN + 2);
    drv = 1'b1; clr_n = 1'b1;
    cyc(1);
    chk("R8 clear with tied input", int'(fault_n), 1);
    cyc(3);
    chk("R10 no drive until request low", int'(gate_on), 0);
    drv = 1'b0; clr_n = 1'b0; cyc(1);
    drv = 1'b1; clr_n = 1'b1;
    cyc(1);
    chk("R10 next request turns on", int'(gate_on), 1);

    // Random phase, checked cycle by cycle against the reference
    burst = 0;
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 30) == 0) drv = ~drv;
      if (($urandom % 12) == 0) trip = ~trip;
      if (burst > 0) begin
        burst--;
        clr_n = (burst == 0);
      end else if (($urandom % 150) == 0) begin
        burst = 1 + ($urandom % (2 * P_RMIN));
        clr_n = 1'b0;
      end
      cyc(1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule